// File: doc/BRIEF.md
# Register Stack Expression Evaluator

This block is a last-in-first-out stack of words held in a small register array, with a stack pointer that counts downward as entries are added. Alongside the pointer it keeps a full flag and an empty flag. Commands arrive one per clock, qualified by a valid strobe. They can push a word, pop a word into an output data register, or combine the two topmost entries by addition or multiplication. Together these let a host evaluate an expression given in postfix (reverse Polish) order by streaming operands and operators into the block.

The pointer starts one past the last storage slot, so an empty stack of `DEPTH` slots has pointer value `DEPTH`. A push first steps the pointer down and then writes the slot it now names. A pop first reads the slot under the pointer and then steps the pointer up. An arithmetic command writes its result into the second slot and steps the pointer up, so the stack loses one entry. Results keep only the low `WORD_W` bits. A command that the stack cannot serve changes nothing and raises an error pulse lasting one cycle. The current top entry is always shown on an output port.

Top module: `rpn_stack_eval`

## Requirements
- R1: After reset, and whenever reset is asserted again, the stack holds no entries: `empty`=1, `full`=0, `err`=0, `tos`=0 and `dout`=0.
- R2: A push (`cmd_op`=2'b00) to a stack that is not full makes `din` the new top entry, shown on `tos` in the cycle after the command, and clears `empty`.
- R3: A push that fills the last of the `DEPTH` slots (11 by default) sets `full`. A push while `full` is ignored: `tos` and `full` stay as they were, and `err` is 1 for one cycle.
- R4: A pop (`cmd_op`=2'b01) of a stack that is not empty loads the old top entry into `dout` and exposes the entry beneath it on `tos`. It clears `full`.
- R5: A pop that removes the last entry sets `empty`, and `tos` then reads 0. A pop while `empty` is ignored: `dout` keeps its value and `err` is 1 for one cycle.
- R6: An add (`cmd_op`=2'b10) with at least two entries replaces the top two entries with their sum, modulo 2^`WORD_W`. The stack loses one entry.
- R7: A multiply (`cmd_op`=2'b11) with at least two entries replaces the top two entries with the low `WORD_W` bits of their product. The stack loses one entry.
- R8: An add or multiply issued with fewer than two entries is ignored. `tos`, `full` and `empty` keep their values, and `err` is 1 for one cycle.
- R9: `full` and `empty` are never 1 together. `full` is 1 exactly when all slots are occupied, and `empty` is 1 exactly when none is.
- R10: A cycle with `cmd_valid`=0 changes no output. `err` is 0 in the cycle after any command that is accepted or absent.
- R11: The command stream push 3, push 4, multiply, push 5, push 6, multiply, add leaves 42 on `tos`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Command: 00 push, 01 pop, 10 add, 11 multiply |
| din | input | WORD_W | Word written by a push |
| dout | output | WORD_W | Data register, loaded by each accepted pop |
| tos | output | WORD_W | Current top entry, 0 when empty |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| err | output | 1 | One-cycle pulse after a rejected command |

## Verification
Every result is due exactly one clock after its command. `tos`, `full`, `empty`, `err` and `dout` all come from registers updated on the edge that accepts the command, and `tos` is a read of the slot under the updated pointer. The bench drives a command on a falling edge and lets one rising edge pass. It then samples every output on the next falling edge, before it drives the following command. This keeps each check inside the single cycle in which its result first shows. The error pulse is also checked one cycle later to confirm that it has cleared.

// File: rtl/rpn_stack_pkg.sv
package rpn_stack_pkg;

   typedef enum logic [1:0] {
      OP_PUSH = 2'b00,
      OP_POP  = 2'b01,
      OP_ADD  = 2'b10,
      OP_MUL  = 2'b11
   } stk_op_e;

endpackage

// File: rtl/rpn_stack_ptr.sv
module rpn_stack_ptr #(
   parameter int DEPTH = 11,
   parameter int SP_W  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            grow,
   input  logic            shrink,
   output logic [SP_W-1:0] sp,
   output logic            full,
   output logic            empty
);

   localparam logic [SP_W-1:0] SP_BOTTOM = SP_W'(DEPTH);
   localparam logic [SP_W-1:0] SP_LAST   = SP_W'(DEPTH - 1);
   localparam logic [SP_W-1:0] SP_ONE    = SP_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp    <= SP_BOTTOM;
         full  <= 1'b0;
         empty <= 1'b1;
      end else if (grow) begin
         sp    <= sp - SP_ONE;
         empty <= 1'b0;
         if (sp == SP_ONE) full <= 1'b1;
      end else if (shrink) begin
         sp    <= sp + SP_ONE;
         full  <= 1'b0;
         if (sp == SP_LAST) empty <= 1'b1;
      end
   end

   // R3: full flag follows the pointer reaching slot zero
   a_r3_full_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
      full == (sp == '0));
   // R5: empty flag follows the pointer sitting past the last slot
   a_r5_empty_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (sp == SP_BOTTOM));
   // R9: never full and empty together
   a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
   a_r9_single_move: assert property (@(posedge clk) disable iff (!rst_n)
      !(grow && shrink));

endmodule

// File: rtl/rpn_stack_regs.sv
module rpn_stack_regs #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 11,
   parameter int SP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SP_W-1:0]   wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [SP_W-1:0]   rd_idx_a,
   input  logic [SP_W-1:0]   rd_idx_b,
   output logic [WORD_W-1:0] rd_a,
   output logic [WORD_W-1:0] rd_b
);

   logic [WORD_W-1:0] slot [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot[gi] <= '0;
         else if (wr_en && (wr_idx == SP_W'(gi)))
            slot[gi] <= wr_data;
      end
   end

   // Out-of-range indices read as zero.
   always_comb begin
      rd_a = '0;
      rd_b = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx_a == SP_W'(i)) rd_a = slot[i];
         if (rd_idx_b == SP_W'(i)) rd_b = slot[i];
      end
   end

   // R2: writes only ever land inside the storage range
   a_r2_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx < SP_W'(DEPTH)));

endmodule

// File: rtl/rpn_stack_alu.sv
module rpn_stack_alu #(
   parameter int WORD_W = 16
) (
   input  logic              sel_mul,
   input  logic [WORD_W-1:0] opnd_top,
   input  logic [WORD_W-1:0] opnd_next,
   output logic [WORD_W-1:0] result
);

   logic [WORD_W-1:0] sum_w;
   logic [WORD_W-1:0] prod_w;

   assign sum_w  = opnd_next + opnd_top;
   assign prod_w = opnd_next * opnd_top;
   assign result = sel_mul ? prod_w : sum_w;

endmodule

// File: rtl/rpn_stack_eval.sv
module rpn_stack_eval
   import rpn_stack_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout,
   output logic [WORD_W-1:0] tos,
   output logic              full,
   output logic              empty,
   output logic              err
);

   localparam int SP_W = $clog2(DEPTH + 1);
   localparam logic [SP_W-1:0] SP_ONE       = SP_W'(1);
   localparam logic [SP_W-1:0] SP_PAIR_LIM  = SP_W'(DEPTH - 1);

   if (DEPTH < 2 || WORD_W < 2) begin : g_bad_cfg
      $error("rpn_stack_eval: DEPTH and WORD_W must both be at least 2");
   end

   stk_op_e           op;
   logic [SP_W-1:0]   sp;
   logic              acc_push, acc_pop, acc_arith, accepted;
   logic [SP_W-1:0]   wr_idx;
   logic [WORD_W-1:0] wr_data, rd_top, rd_next, alu_res;

   assign op = stk_op_e'(cmd_op);

   always_comb begin
      acc_push  = 1'b0;
      acc_pop   = 1'b0;
      acc_arith = 1'b0;
      if (cmd_valid) begin
         unique case (op)
            OP_PUSH: acc_push  = !full;
            OP_POP:  acc_pop   = !empty;
            default: acc_arith = (sp < SP_PAIR_LIM);
         endcase
      end
   end

   assign accepted = acc_push || acc_pop || acc_arith;
   assign wr_idx   = acc_push ? (sp - SP_ONE) : (sp + SP_ONE);
   assign wr_data  = acc_push ? din : alu_res;

   rpn_stack_ptr #(.DEPTH(DEPTH), .SP_W(SP_W)) i_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .grow   (acc_push),
      .shrink (acc_pop || acc_arith),
      .sp     (sp),
      .full   (full),
      .empty  (empty)
   );

   rpn_stack_regs #(.WORD_W(WORD_W), .DEPTH(DEPTH), .SP_W(SP_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (acc_push || acc_arith),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rd_idx_a (sp),
      .rd_idx_b (sp + SP_ONE),
      .rd_a     (rd_top),
      .rd_b     (rd_next)
   );

   rpn_stack_alu #(.WORD_W(WORD_W)) i_alu (
      .sel_mul   (op == OP_MUL),
      .opnd_top  (rd_top),
      .opnd_next (rd_next),
      .result    (alu_res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
         err  <= 1'b0;
      end else begin
         err <= cmd_valid && !accepted;
         if (acc_pop) dout <= rd_top;
      end
   end

   assign tos = rd_top;

   // R2: a served push shows its word on top next cycle
   a_r2_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b00 && !full) |=> (tos == $past(din)));
   // R4: a served pop hands the old top to the data register
   a_r4_pop_to_dout: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b01 && !empty) |=> (dout == $past(tos)));
   // R8: arithmetic on fewer than two entries is refused
   a_r8_short_arith_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op[1] && (empty || sp == SP_W'(DEPTH - 1)))
         |=> (err && $stable(tos) && $stable(empty)));
   // R10: idle cycles leave all outputs alone and clear the error pulse
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(tos) && $stable(dout) && $stable(full) && !err));

endmodule

// File: tb/test_rpn_stack_eval.sv
`timescale 1ns/1ps
module test_rpn_stack_eval;

   localparam int W = 16;
   localparam int N = 11;
   localparam int ROWS = 19;

   // {req[41:38], valid[37], op[36:35], din[34:19], tos[18:3], full[2], empty[1], err[0]}
   localparam logic [41:0] VEC [ROWS] = '{
      {4'd11, 1'b1, 2'b00, 16'h0003, 16'h0003, 1'b0, 1'b0, 1'b0},
      {4'd11, 1'b1, 2'b00, 16'h0004, 16'h0004, 1'b0, 1'b0, 1'b0},
      {4'd7,  1'b1, 2'b11, 16'h0000, 16'h000C, 1'b0, 1'b0, 1'b0},
      {4'd11, 1'b1, 2'b00, 16'h0005, 16'h0005, 1'b0, 1'b0, 1'b0},
      {4'd11, 1'b1, 2'b00, 16'h0006, 16'h0006, 1'b0, 1'b0, 1'b0},
      {4'd7,  1'b1, 2'b11, 16'h0000, 16'h001E, 1'b0, 1'b0, 1'b0},
      {4'd11, 1'b1, 2'b10, 16'h0000, 16'h002A, 1'b0, 1'b0, 1'b0},
      {4'd5,  1'b1, 2'b01, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0},
      {4'd8,  1'b1, 2'b10, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1},
      {4'd2,  1'b1, 2'b00, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0},
      {4'd2,  1'b1, 2'b00, 16'h0002, 16'h0002, 1'b0, 1'b0, 1'b0},
      {4'd6,  1'b1, 2'b10, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b0},
      {4'd8,  1'b1, 2'b11, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1},
      {4'd10, 1'b0, 2'b00, 16'hBEEF, 16'h0001, 1'b0, 1'b0, 1'b0},
      {4'd2,  1'b1, 2'b00, 16'h0100, 16'h0100, 1'b0, 1'b0, 1'b0},
      {4'd7,  1'b1, 2'b11, 16'h0000, 16'h0100, 1'b0, 1'b0, 1'b0},
      {4'd2,  1'b1, 2'b00, 16'h0100, 16'h0100, 1'b0, 1'b0, 1'b0},
      {4'd7,  1'b1, 2'b11, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0},
      {4'd5,  1'b1, 2'b01, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [1:0]   cmd_op = 2'b00;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout, tos;
   logic         full, empty, err;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rpn_stack_eval #(.WORD_W(W), .DEPTH(N)) i_rpn_stack_eval (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .din(din), .dout(dout), .tos(tos), .full(full), .empty(empty), .err(err)
   );

   function automatic string rname(input logic [3:0] id);
      case (id)
         4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
         4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
         4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
         4'd10: return "R10"; default: return "R11";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic v, input logic [1:0] op, input logic [W-1:0] d);
      cmd_valid = v;
      cmd_op    = op;
      din       = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL R10 watchdog: actual %0d cycles expected below 20000", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", "tos", tos, '0);
      check("R1", "dout", dout, '0);
      check("R1", "empty", W'(empty), W'(1));
      check("R1", "full", W'(full), W'(0));
      check("R1", "err", W'(err), W'(0));

      // Vector table: results due one cycle after each command
      for (int r = 0; r < ROWS; r++) begin
         issue(VEC[r][37], VEC[r][36:35], VEC[r][34:19]);
         check(rname(VEC[r][41:38]), $sformatf("row %0d tos", r), tos, VEC[r][18:3]);
         check(rname(VEC[r][41:38]), $sformatf("row %0d flags", r),
               W'({full, empty, err}), W'(VEC[r][2:0]));
         if (r == 7) check("R4", "dout after popping 42", dout, 16'h002A);
      end

      // R3: fill every slot
      for (int i = 0; i < N; i++) begin
         issue(1'b1, 2'b00, W'(100 + i));
         if (i == N - 2) check("R3", "full before last slot", W'(full), W'(0));
      end
      check("R3", "full after last slot", W'(full), W'(1));
      check("R3", "tos after fill", tos, W'(110));
      issue(1'b1, 2'b00, 16'h7777);
      check("R3", "push on full err", W'(err), W'(1));
      check("R3", "push on full tos", tos, W'(110));
      check("R9", "still full", W'({full, empty}), W'(2'b10));
      issue(1'b0, 2'b00, 16'h0000);
      check("R10", "err one cycle", W'(err), W'(0));

      // R4 and R9: one pop clears full
      issue(1'b1, 2'b01, 16'h0000);
      check("R4", "pop dout", dout, W'(110));
      check("R4", "pop tos", tos, W'(109));
      check("R9", "pop clears full", W'(full), W'(0));

      // R5: drain to empty
      for (int i = 0; i < N - 1; i++) issue(1'b1, 2'b01, 16'h0000);
      check("R5", "last pop dout", dout, W'(100));
      check("R5", "empty after drain", W'({full, empty}), W'(2'b01));
      check("R5", "tos when empty", tos, '0);
      issue(1'b1, 2'b01, 16'h0000);
      check("R5", "pop on empty err", W'(err), W'(1));
      check("R5", "pop on empty dout kept", dout, W'(100));

      // R10: idle with changing din changes nothing
      issue(1'b1, 2'b00, 16'h00AA);
      issue(1'b0, 2'b00, 16'h5555);
      check("R10", "idle tos", tos, 16'h00AA);
      check("R10", "idle err", W'(err), W'(0));

      // R1: reset in mid-stream
      issue(1'b1, 2'b00, 16'h00BB);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1", "re-reset tos", tos, '0);
      check("R1", "re-reset flags", W'({full, empty, err}), W'(3'b010));
      check("R1", "re-reset dout", dout, '0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule